// File: doc/BRIEF.md
# 128-bit Four-Instruction Hart

This block is a small single-issue core with a 128-bit datapath. It keeps thirty-two 128-bit general registers and a 128-bit program counter. It reads 32-bit instruction words from an on-chip ROM of 16 KiB that is mapped at byte address 0x2000_0000. The core executes one instruction in two clock cycles: the first cycle checks the fetch address and reads the ROM, and the second decodes the word and executes it.

Four instructions are implemented: add-immediate, load-upper-immediate, branch-if-equal and the environment call. Any other word, and any fetch from a bad address, stops the core with an exception code. The environment call also stops the core. While it is stopped, an external service unit can read argument registers a0 to a7 (x10 to x17). The unit then releases the core with a resume pulse. That pulse writes two result values into a0 and a1 and moves the program counter past the stopped instruction.

The ROM is filled through a write port, normally while reset is held.

Top module: `hart128_core`

## Requirements
- R1: After reset the program counter is 0x2000_0000, all 32 registers read zero and no exception is flagged.
- R2: A fetch whose address is not a multiple of 4, or that lies below 0x2000_0000 or at or above 0x2000_4000, stops the core with code 2 and leaves the program counter at that address. The last word, at 0x2000_3FFC, fetches normally.
- R3: Decoding uses opcode bits 6:0 and funct3 bits 14:12. Add-immediate is 0010011 with funct3 000. Load-upper is 0110111. Branch-if-equal is 1100011 with funct3 000. The environment call is only the exact word 0x00000073. Any other word stops the core with code 1.
- R4: Add-immediate writes register rd (bits 11:7) with rs1 (bits 19:15) plus bits 31:20. Those bits are zero-extended to 128 bits, so 0xFFF adds 4095. The program counter then advances by 4.
- R5: Load-upper writes rd with bits 31:12 shifted left by 12 and zero-extended. The program counter then advances by 4.
- R6: Branch-if-equal compares rs1 with rs2 (bits 24:20). The offset has bit 12 from instruction bit 31, bit 11 from bit 7, bits 10:5 from bits 30:25, bits 4:1 from bits 11:8, and bit 0 zero. It is sign-extended from bit 12. If the registers are equal, the offset is added to the program counter; if not, 4 is added.
- R7: Writes to register x0 are discarded, and x0 always reads as zero.
- R8: The environment call stops the core with code 3 and leaves the program counter on the call word.
- R9: While stopped, exc_valid_o stays high, and the program counter, the code and the registers stay unchanged until resume_i is sampled high.
- R10: A resume while stopped writes wb_a0_i into a0 and wb_a1_i into a1, adds 4 to the program counter, clears the code to 0 and starts the next fetch.
- R11: Each instruction takes exactly two cycles. Register and program-counter results appear on the outputs at the second rising edge after the fetch cycle begins. A fetch fault is flagged one edge after its fetch cycle. The code reads 0 whenever exc_valid_o is low.
- R12: trap_args_o carries x10 to x17 packed with x10 in bits 127:0 and x17 in the top slice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_we_i | input | 1 | ROM word write enable |
| load_addr_i | input | 12 | ROM word index |
| load_data_i | input | 32 | ROM word data |
| resume_i | input | 1 | Release the stopped core |
| wb_a0_i | input | 128 | Value written to a0 on resume |
| wb_a1_i | input | 128 | Value written to a1 on resume |
| exc_valid_o | output | 1 | Core is stopped with an exception |
| exc_code_o | output | 2 | 0 none, 1 illegal, 2 fetch fault, 3 environment call |
| pc_o | output | 128 | Program counter |
| trap_args_o | output | 1024 | Registers x10 to x17 |

## Verification
Each instruction's effect is due two edges after its fetch cycle starts. A fetch fault is due after one edge, and the effect of a resume after one edge. The bench's behavioural model advances one step per clock on the same inputs. Both the model and the core are compared at the falling edge after every rising edge, so any result that arrives a cycle early or late is a miscompare. At each stop, extra checks compare the code, the program counter and selected argument registers with hand-derived values: zero-extended immediates, the loop count of a backward branch, and fault addresses at both ends of the ROM window.

// File: rtl/hart128_pkg.sv
`timescale 1ns/1ps
package hart128_pkg;

  typedef enum logic [1:0] {
    EXC_NONE    = 2'd0,
    EXC_ILLEGAL = 2'd1,
    EXC_FETCH   = 2'd2,
    EXC_ECALL   = 2'd3
  } exc_e;

  typedef enum logic [2:0] {
    OP_ADDI,
    OP_LUI,
    OP_BEQ,
    OP_ECALL,
    OP_BAD
  } op_e;

  typedef enum logic [1:0] {
    ST_FETCH,
    ST_EXEC,
    ST_HALT
  } state_e;

  localparam logic [6:0]  OPC_IMM    = 7'b0010011;
  localparam logic [6:0]  OPC_LUI    = 7'b0110111;
  localparam logic [6:0]  OPC_BRANCH = 7'b1100011;
  localparam logic [2:0]  F3_ZERO    = 3'b000;
  localparam logic [31:0] ECALL_WORD = 32'h0000_0073;

  typedef struct packed {
    op_e         op;
    logic [4:0]  rd;
    logic [4:0]  rs1;
    logic [4:0]  rs2;
    logic [11:0] imm12;
    logic [19:0] imm20;
    logic [12:0] boff;
  } dec_t;

endpackage

// File: rtl/hart128_rom.sv
`timescale 1ns/1ps
module hart128_rom #(
  parameter int unsigned WORDS = 4096,
  localparam int unsigned AW   = $clog2(WORDS)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [31:0]   wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [31:0]   rdata_o
);

  logic [31:0] mem [WORDS];
  logic [31:0] rdata_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    if (re_i) rdata_q <= mem[raddr_i];
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/hart128_decode.sv
`timescale 1ns/1ps
module hart128_decode
  import hart128_pkg::*;
(
  input  logic [31:0] insn_i,
  output dec_t        dec_o
);

  logic [6:0] opc;
  logic [2:0] f3;

  assign opc = insn_i[6:0];
  assign f3  = insn_i[14:12];

  always_comb begin
    dec_o.rd    = insn_i[11:7];
    dec_o.rs1   = insn_i[19:15];
    dec_o.rs2   = insn_i[24:20];
    dec_o.imm12 = insn_i[31:20];
    dec_o.imm20 = insn_i[31:12];
    // scattered branch offset, bit 0 implied zero
    dec_o.boff  = {insn_i[31], insn_i[7], insn_i[30:25], insn_i[11:8], 1'b0};
    if (opc == OPC_IMM && f3 == F3_ZERO)         dec_o.op = OP_ADDI;
    else if (opc == OPC_LUI)                     dec_o.op = OP_LUI;
    else if (opc == OPC_BRANCH && f3 == F3_ZERO) dec_o.op = OP_BEQ;
    else if (insn_i == ECALL_WORD)               dec_o.op = OP_ECALL;
    else                                         dec_o.op = OP_BAD;
  end

endmodule

// File: rtl/hart128_regfile.sv
`timescale 1ns/1ps
module hart128_regfile #(
  parameter int unsigned XLEN     = 128,
  parameter int unsigned NREG     = 32,
  parameter int unsigned ARG_BASE = 10,
  parameter int unsigned NARG     = 8,
  localparam int unsigned AW      = $clog2(NREG)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [AW-1:0]        waddr_i,
  input  logic [XLEN-1:0]      wdata_i,
  input  logic                 trap_we_i,
  input  logic [XLEN-1:0]      trap_a0_i,
  input  logic [XLEN-1:0]      trap_a1_i,
  input  logic [AW-1:0]        raddr_a_i,
  input  logic [AW-1:0]        raddr_b_i,
  output logic [XLEN-1:0]      rdata_a_o,
  output logic [XLEN-1:0]      rdata_b_o,
  output logic [NARG*XLEN-1:0] args_o
);

  logic [XLEN-1:0] regs [NREG];

  assign regs[0] = '0;  // no storage behind x0

  for (genvar i = 1; i < NREG; i++) begin : g_reg
    logic [XLEN-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              q <= '0;
      else if (trap_we_i && i == ARG_BASE)      q <= trap_a0_i;
      else if (trap_we_i && i == ARG_BASE + 1)  q <= trap_a1_i;
      else if (we_i && waddr_i == AW'(i))       q <= wdata_i;
    end
    assign regs[i] = q;
  end

  for (genvar k = 0; k < NARG; k++) begin : g_arg
    assign args_o[k*XLEN +: XLEN] = regs[ARG_BASE + k];
  end

  assign rdata_a_o = regs[raddr_a_i];
  assign rdata_b_o = regs[raddr_b_i];

  a_r10_wb_a0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_we_i |=> args_o[XLEN-1:0] == $past(trap_a0_i));
  a_r10_wb_a1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_we_i |=> args_o[2*XLEN-1:XLEN] == $past(trap_a1_i));

endmodule

// File: rtl/hart128_core.sv
`timescale 1ns/1ps
module hart128_core
  import hart128_pkg::*;
#(
  parameter int unsigned XLEN      = 128,
  parameter logic [31:0] BASE_ADDR = 32'h2000_0000,
  parameter int unsigned ROM_BYTES = 32'h4000
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            load_we_i,
  input  logic [$clog2(ROM_BYTES/4)-1:0]  load_addr_i,
  input  logic [31:0]                     load_data_i,
  input  logic                            resume_i,
  input  logic [XLEN-1:0]                 wb_a0_i,
  input  logic [XLEN-1:0]                 wb_a1_i,
  output logic                            exc_valid_o,
  output logic [1:0]                      exc_code_o,
  output logic [XLEN-1:0]                 pc_o,
  output logic [8*XLEN-1:0]               trap_args_o
);

  localparam int unsigned   WORDS  = ROM_BYTES / 4;
  localparam int unsigned   AW     = $clog2(WORDS);
  localparam logic [XLEN-1:0] BASE_X = XLEN'(BASE_ADDR);
  localparam logic [XLEN-1:0] END_X  = BASE_X + XLEN'(ROM_BYTES);

  state_e          state_q, state_d;
  exc_e            code_q, code_d;
  logic [XLEN-1:0] pc_q, pc_d;
  logic [XLEN-1:0] pc_off, pc_plus4, br_tgt;
  logic            fetch_ok;
  logic [31:0]     insn;
  dec_t            dec;
  logic [XLEN-1:0] rs1_val, rs2_val, wdata;
  logic            rf_we, trap_we;

  assign pc_off   = pc_q - BASE_X;
  assign fetch_ok = (pc_q[1:0] == 2'b00) && (pc_q >= BASE_X) && (pc_q < END_X);
  assign pc_plus4 = pc_q + XLEN'(4);
  assign br_tgt   = pc_q + {{(XLEN-13){dec.boff[12]}}, dec.boff};

  hart128_rom #(.WORDS(WORDS)) u_rom (
    .clk_i   (clk_i),
    .we_i    (load_we_i),
    .waddr_i (load_addr_i),
    .wdata_i (load_data_i),
    .re_i    (state_q == ST_FETCH && fetch_ok),
    .raddr_i (pc_off[AW+1:2]),
    .rdata_o (insn)
  );

  hart128_decode u_dec (
    .insn_i (insn),
    .dec_o  (dec)
  );

  hart128_regfile #(.XLEN(XLEN)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (rf_we),
    .waddr_i   (dec.rd),
    .wdata_i   (wdata),
    .trap_we_i (trap_we),
    .trap_a0_i (wb_a0_i),
    .trap_a1_i (wb_a1_i),
    .raddr_a_i (dec.rs1),
    .raddr_b_i (dec.rs2),
    .rdata_a_o (rs1_val),
    .rdata_b_o (rs2_val),
    .args_o    (trap_args_o)
  );

  always_comb begin
    state_d = state_q;
    code_d  = code_q;
    pc_d    = pc_q;
    rf_we   = 1'b0;
    trap_we = 1'b0;
    wdata   = '0;
    unique case (state_q)
      ST_FETCH: begin
        if (fetch_ok) state_d = ST_EXEC;
        else begin
          state_d = ST_HALT;
          code_d  = EXC_FETCH;
        end
      end
      ST_EXEC: begin
        state_d = ST_FETCH;
        unique case (dec.op)
          OP_ADDI: begin
            rf_we = 1'b1;
            wdata = rs1_val + XLEN'(dec.imm12);
            pc_d  = pc_plus4;
          end
          OP_LUI: begin
            rf_we = 1'b1;
            wdata = XLEN'({dec.imm20, 12'h000});
            pc_d  = pc_plus4;
          end
          OP_BEQ: pc_d = (rs1_val == rs2_val) ? br_tgt : pc_plus4;
          OP_ECALL: begin
            state_d = ST_HALT;
            code_d  = EXC_ECALL;
          end
          default: begin
            state_d = ST_HALT;
            code_d  = EXC_ILLEGAL;
          end
        endcase
      end
      default: begin
        if (resume_i) begin
          trap_we = 1'b1;
          pc_d    = pc_plus4;
          code_d  = EXC_NONE;
          state_d = ST_FETCH;
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_FETCH;
      code_q  <= EXC_NONE;
      pc_q    <= BASE_X;
    end else begin
      state_q <= state_d;
      code_q  <= code_d;
      pc_q    <= pc_d;
    end
  end

  assign exc_valid_o = (state_q == ST_HALT);
  assign exc_code_o  = code_q;
  assign pc_o        = pc_q;

  a_r8_ecall_parks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_EXEC && dec.op == OP_ECALL)
      |=> exc_valid_o && exc_code_o == EXC_ECALL && pc_o == $past(pc_o));

  a_r9_halt_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_valid_o && !resume_i)
      |=> exc_valid_o && $stable(pc_o) && $stable(exc_code_o) && $stable(trap_args_o));

  a_r10_resume_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_valid_o && resume_i) |=> !exc_valid_o && pc_o == $past(pc_o) + XLEN'(4));

  a_r2_misaligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FETCH && pc_o[1:0] != 2'b00)
      |=> exc_valid_o && exc_code_o == EXC_FETCH && $stable(pc_o));

  a_r4_seq_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_EXEC && (dec.op == OP_ADDI || dec.op == OP_LUI))
      |=> pc_o == $past(pc_o) + XLEN'(4));

  a_r11_code_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exc_valid_o |-> exc_code_o == EXC_NONE);

endmodule

// File: tb/hart128_core_bench.sv
`timescale 1ns/1ps
module hart128_core_bench;

  localparam logic [127:0] BASE = 128'h2000_0000;
  localparam int unsigned  NW   = 4096;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          load_we_i = 1'b0;
  logic [11:0]   load_addr_i = '0;
  logic [31:0]   load_data_i = '0;
  logic          resume_i = 1'b0;
  logic [127:0]  wb_a0_i = '0;
  logic [127:0]  wb_a1_i = '0;
  logic          exc_valid_o;
  logic [1:0]    exc_code_o;
  logic [127:0]  pc_o;
  logic [1023:0] trap_args_o;

  always #10 clk_i = ~clk_i;

  hart128_core u_hart128_core (
    .clk_i, .rst_ni, .load_we_i, .load_addr_i, .load_data_i,
    .resume_i, .wb_a0_i, .wb_a1_i,
    .exc_valid_o, .exc_code_o, .pc_o, .trap_args_o
  );

  int n_chk = 0;
  int n_bad = 0;
  string cur_req = "R11";

  // reference model
  logic [31:0]  prog [NW];
  logic [127:0] mx [32];
  logic [127:0] m_pc;
  logic [31:0]  m_ir;
  int           m_st;   // 0 fetch, 1 execute, 2 stopped
  int           m_code;

  function automatic logic [31:0] enc_i(int rd, int rs1, int imm);
    logic [11:0] im = imm[11:0];
    return {im, rs1[4:0], 3'b000, rd[4:0], 7'h13};
  endfunction
  function automatic logic [31:0] enc_u(int rd, int imm);
    logic [19:0] im = imm[19:0];
    return {im, rd[4:0], 7'h37};
  endfunction
  function automatic logic [31:0] enc_b(int rs1, int rs2, int off);
    logic [12:0] o = off[12:0];
    return {o[12], o[10:5], rs2[4:0], rs1[4:0], 3'b000, o[4:1], o[11], 7'h63};
  endfunction

  task automatic check(string req, string what, logic [1023:0] act, logic [1023:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [1023:0] m_args();
    logic [1023:0] a;
    for (int k = 0; k < 8; k++) a[k*128 +: 128] = mx[10+k];
    return a;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 32; i++) mx[i] = '0;
    m_pc = BASE; m_st = 0; m_code = 0; m_ir = '0;
  endtask

  task automatic model_step();
    logic [6:0] op; logic [2:0] f3; int rd, rs1, rs2;
    logic [12:0] off;
    case (m_st)
      0: begin
        if (m_pc[1:0] != 0 || m_pc < BASE || m_pc >= BASE + 128'h4000) begin
          m_st = 2; m_code = 2;
        end else begin
          m_ir = prog[32'((m_pc - BASE) >> 2)];
          m_st = 1;
        end
      end
      1: begin
        op = m_ir[6:0]; f3 = m_ir[14:12];
        rd = int'(m_ir[11:7]); rs1 = int'(m_ir[19:15]); rs2 = int'(m_ir[24:20]);
        m_st = 0;
        if (op == 7'h13 && f3 == 0) begin
          if (rd != 0) mx[rd] = mx[rs1] + 128'(m_ir[31:20]);
          m_pc = m_pc + 4;
        end else if (op == 7'h37) begin
          if (rd != 0) mx[rd] = 128'({m_ir[31:12], 12'h000});
          m_pc = m_pc + 4;
        end else if (op == 7'h63 && f3 == 0) begin
          off = {m_ir[31], m_ir[7], m_ir[30:25], m_ir[11:8], 1'b0};
          if (mx[rs1] == mx[rs2]) m_pc = m_pc + {{115{off[12]}}, off};
          else m_pc = m_pc + 4;
        end else if (m_ir == 32'h73) begin
          m_st = 2; m_code = 3;
        end else begin
          m_st = 2; m_code = 1;
        end
      end
      default: begin
        if (resume_i) begin
          mx[10] = wb_a0_i; mx[11] = wb_a1_i;
          m_pc = m_pc + 4; m_code = 0; m_st = 0;
        end
      end
    endcase
  endtask

  task automatic compare();
    check(cur_req, "pc", 1024'(pc_o), 1024'(m_pc));
    check(cur_req, "exc_valid", 1024'(exc_valid_o), 1024'(m_st == 2));
    check(cur_req, "exc_code", 1024'(exc_code_o), 1024'(m_code));
    check(cur_req, "args", trap_args_o, m_args());
  endtask

  // inputs are settled at a falling edge; model takes the coming rising edge
  task automatic step();
    model_step();
    @(negedge clk_i);
    compare();
  endtask

  task automatic boot();
    rst_ni = 1'b0;
    resume_i = 1'b0;
    for (int i = 0; i < NW; i++) begin
      @(negedge clk_i);
      load_we_i = 1'b1; load_addr_i = 12'(i); load_data_i = prog[i];
    end
    @(negedge clk_i);
    load_we_i = 1'b0;
    model_reset();
    rst_ni = 1'b1;
    #1;
    check("R1", "reset pc", 1024'(pc_o), 1024'(BASE));
    check("R1", "reset exc_valid", 1024'(exc_valid_o), 1024'(0));
    check("R1", "reset args", trap_args_o, '0);
  endtask

  task automatic run_to_stop(string req, int code, int maxc);
    cur_req = req;
    for (int i = 0; i < maxc && !exc_valid_o; i++) step();
    check(req, "stop code", 1024'(exc_code_o), 1024'(code));
  endtask

  task automatic wait_resume(string req, logic [127:0] a0, logic [127:0] a1);
    cur_req = "R9";
    for (int i = 0; i < 3; i++) step();
    cur_req = req;
    wb_a0_i = a0; wb_a1_i = a1; resume_i = 1'b1;
    step();
    resume_i = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // scenario A: arithmetic, call, branches, illegal words, misaligned fetch
    for (int i = 0; i < NW; i++) prog[i] = '0;
    prog[0]  = enc_i(10, 0, 'h10);
    prog[1]  = enc_u(11, 'hABCDE);
    prog[2]  = enc_i(11, 11, 'hFFF);
    prog[3]  = enc_i(0, 10, 5);
    prog[4]  = enc_i(12, 0, 7);
    prog[5]  = 32'h0000_0073;
    prog[6]  = enc_b(10, 11, 8);
    prog[7]  = enc_b(12, 12, 12);
    prog[10] = enc_i(16, 0, 3);
    prog[11] = enc_b(0, 0, 4);
    prog[12] = enc_i(15, 15, 1);
    prog[13] = enc_b(15, 16, 8);
    prog[14] = enc_b(0, 0, -8);
    prog[15] = 32'h0000_0000;
    prog[16] = 32'h0000_1013;
    prog[17] = 32'h0010_0073;
    prog[18] = enc_b(0, 0, 2);
    boot();

    run_to_stop("R8", 3, 40);
    check("R8", "call pc", 1024'(pc_o), 1024'(BASE + 'h14));
    check("R4", "a0 small imm", 1024'(trap_args_o[127:0]), 1024'(128'h10));
    check("R5", "a1 zero-extended", 1024'(trap_args_o[255:128]), 1024'(128'hABCD_EFFF));
    check("R7", "a2 from x0", 1024'(trap_args_o[383:256]), 1024'(128'h7));
    wait_resume("R10", {1'b1, 123'd0, 4'h5}, '1);
    check("R10", "a0 written back", 1024'(trap_args_o[127:0]), 1024'({1'b1, 123'd0, 4'h5}));
    check("R12", "a1 slice", 1024'(trap_args_o[255:128]), 1024'({128{1'b1}}));

    run_to_stop("R6", 1, 80);
    check("R6", "loop count a5", 1024'(trap_args_o[767:640]), 1024'(128'd3));
    check("R3", "zero word pc", 1024'(pc_o), 1024'(BASE + 'h3C));
    wait_resume("R10", '0, '0);
    run_to_stop("R3", 1, 10);
    wait_resume("R10", '0, '0);
    run_to_stop("R3", 1, 10);
    check("R3", "near-call word pc", 1024'(pc_o), 1024'(BASE + 'h44));
    wait_resume("R10", '0, '0);
    run_to_stop("R2", 2, 10);
    check("R2", "misaligned pc", 1024'(pc_o), 1024'(BASE + 'h4A));
    wait_resume("R10", '0, '0);
    run_to_stop("R2", 2, 10);

    // scenario B: hop to the top of the window and run off its end
    for (int i = 0; i < NW; i++) prog[i] = '0;
    prog[0]    = enc_b(0, 0, 4092);
    prog[1023] = enc_b(0, 0, 4092);
    prog[2046] = enc_b(0, 0, 4092);
    prog[3069] = enc_b(0, 0, 4092);
    prog[4092] = enc_i(17, 0, 'h7FF);
    prog[4093] = enc_i(13, 13, 1);
    prog[4094] = enc_i(13, 13, 1);
    prog[4095] = enc_i(13, 13, 1);
    boot();
    run_to_stop("R2", 2, 40);
    check("R2", "end fault pc", 1024'(pc_o), 1024'(BASE + 'h4000));
    check("R2", "last word ran", 1024'(trap_args_o[511:384]), 1024'(128'd3));
    check("R12", "a7 slice", 1024'(trap_args_o[1023:896]), 1024'(128'h7FF));

    // scenario C: branch below the window
    for (int i = 0; i < NW; i++) prog[i] = '0;
    prog[0] = enc_b(0, 0, -4);
    boot();
    run_to_stop("R2", 2, 10);
    check("R2", "below-window pc", 1024'(pc_o), 1024'(BASE - 4));

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule